// File: doc/BRIEF.md
# Single-Memory 8-Bit Accumulator Microcontroller

This block is a very small sequential processor for utility work inside a larger chip: a peripheral sequencer, a protocol helper or a simple state machine written as code. It keeps one 8-bit accumulator, one carry flag and an 8-bit program counter. Everything else lives in one 512-byte memory with one read port and one write port. The lower 256 bytes hold the program. The upper 256 bytes hold data, and the first 16 of those bytes serve as the register file r0 to r15.

Because instruction fetch and operand reads share the single read port, nothing is pipelined. Each instruction takes a fixed 1, 2 or 3 cycles, set by how many memory reads it needs. The write port is free during fetch, so a store to a register costs a single cycle. Code and data are placed through a load port while the core is held in reset. The core then runs from address 0 until it executes the exit instruction, after which it stays halted.

Instruction encoding (bit 7 on the left):
- `0fff_rrrr`: ALU operation with register r.
- `1000_rrrr`: store the accumulator to register r.
- `1001_rrrr`: branch-and-link.
- `1010_rrrr` / `1011_rrrr`: indirect load / indirect store through register r.
- `1100_xfff nn`: ALU operation with the immediate byte nn.
- `1101_xxcc tt`: branch to tt.
- `1110_xxss`: shift.
- `1111_aaaa`: IO.

Top module: `acc8_core`

## Requirements
- R1: While rst_n is low (synchronous, active low), the accumulator, carry, out_valid and halted clear to 0 and the PC clears to 0. The first instruction executed after release is the one at address 0. Its effect is visible 2 cycles after release.
- R2: `0fff_rrrr` combines the accumulator with register r (data address 256+r) using function f and takes 2 cycles. The function codes are: 0 add, 1 subtract, 2 add-with-carry, 3 subtract-with-borrow, 4 and, 5 or, 6 xor, 7 pass (load).
- R3: `1100_xfff` followed by byte nn applies function f to the accumulator and nn. It takes 2 cycles and advances the PC by 2. Bit 3 of the opcode is ignored.
- R4: Carry changes only on arithmetic functions 0 to 3 and on shifts. Add sets carry on unsigned overflow. Subtract computes A+~B+1 and sets carry when there is no borrow. Add-with-carry computes A+B+C, and subtract-with-borrow computes A+~B+C. Functions 4 to 7 leave carry unchanged.
- R5: `1000_rrrr` writes the accumulator into register r in 1 cycle.
- R6: `1010_rrrr` loads the byte at data address 256+m[256+r] into the accumulator in 3 cycles, without touching carry. `1011_rrrr` writes the accumulator to that address in 2 cycles. Data addresses 0 to 15 alias the registers.
- R7: `1101_xxcc tt` takes 2 cycles. It jumps to tt when taken; otherwise the PC advances by 2. The condition cc is: 00 always, 01 when the accumulator is zero, 10 when it is nonzero, 11 never.
- R8: `1001_rrrr tt` writes the address of the following instruction (its own address + 2) into register r and jumps to tt, in 2 cycles.
- R9: `1110_xxss` shifts the accumulator in 1 cycle. The shift select ss is:
  - 00: left, with carry taking bit 7 and a 0 entering.
  - 01: logical right, with carry taking bit 0.
  - 10: rotate left through carry.
  - 11: rotate right through carry.
- R10: The IO instructions take 1 cycle.
  - `1111_0000` copies the accumulator to out_data and pulses out_valid for one cycle, with out_data equal to the accumulator during that pulse.
  - `1111_0001` loads in_data into the accumulator.
  - All other IO selects except 1111 have no effect.
- R11: `1111_1111` halts the core 1 cycle after it is fetched. halted then stays high, no further instruction executes, out_valid stays low and the accumulator holds its value until reset.
- R12: While load_we is high, load_data is written to memory address load_addr (0 to 511). The write takes priority over the core's own write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_we | input | 1 | Preload write enable |
| load_addr | input | 9 | Preload byte address |
| load_data | input | 8 | Preload byte |
| in_data | input | 8 | Input port sampled by the IN instruction |
| out_data | output | 8 | Output port register |
| out_valid | output | 1 | One-cycle strobe for each OUT instruction |
| halted | output | 1 | High after the exit instruction |
| acc_o | output | 8 | Current accumulator value |

## Verification
Any wrong internal state surfaces at the output port because every result passes through the accumulator. A corrupted register, carry or pointer changes the next value emitted by an OUT instruction, at most a few instructions later. Wrong cycle counts show up as the spacing between consecutive out_valid pulses around a single instruction: a misplaced state shifts that spacing by exactly one or more cycles. A wrongly taken or untaken branch either emits a poison value or changes the number of pulses before halted rises.

// File: rtl/acc8_pkg.sv
// Package: shared types and codes for the single-memory accumulator core.
// Assumes an 8-bit instruction byte with the opcode in the top four bits.
package acc8_pkg;

    // Control sequencer states
    typedef enum logic [3:0] {
        ST_BOOT,    // reset exit: first fetch issued
        ST_DEC,     // instruction byte on the read port
        ST_REGOP,   // register operand on the read port
        ST_IMMOP,   // immediate byte on the read port
        ST_BRANCH,  // branch target on the read port
        ST_LDPTR,   // indirect load: pointer on the read port
        ST_LDDAT,   // indirect load: data on the read port
        ST_STPTR,   // indirect store: pointer on the read port
        ST_HALT     // exit executed
    } state_t;

    // ALU function codes (3-bit field)
    localparam logic [2:0] FN_ADD  = 3'd0;
    localparam logic [2:0] FN_SUB  = 3'd1;
    localparam logic [2:0] FN_ADC  = 3'd2;
    localparam logic [2:0] FN_SBB  = 3'd3;
    localparam logic [2:0] FN_AND  = 3'd4;
    localparam logic [2:0] FN_OR   = 3'd5;
    localparam logic [2:0] FN_XOR  = 3'd6;
    localparam logic [2:0] FN_PASS = 3'd7;

    // Shift selects (2-bit field)
    localparam logic [1:0] SH_LEFT  = 2'd0;
    localparam logic [1:0] SH_RIGHT = 2'd1;
    localparam logic [1:0] SH_RLC   = 2'd2;
    localparam logic [1:0] SH_RRC   = 2'd3;

    // Branch condition selects
    localparam logic [1:0] CC_ALWAYS  = 2'd0;
    localparam logic [1:0] CC_ZERO    = 2'd1;
    localparam logic [1:0] CC_NONZERO = 2'd2;

    // Opcode groups (upper nibble, bit 7 set)
    localparam logic [3:0] OP_STREG = 4'h8;
    localparam logic [3:0] OP_BAL   = 4'h9;
    localparam logic [3:0] OP_LDIND = 4'hA;
    localparam logic [3:0] OP_STIND = 4'hB;
    localparam logic [3:0] OP_IMM   = 4'hC;
    localparam logic [3:0] OP_BR    = 4'hD;
    localparam logic [3:0] OP_SHIFT = 4'hE;
    localparam logic [3:0] OP_IO    = 4'hF;

endpackage

// File: rtl/acc8_ram.sv
// Module: program/data memory with one synchronous read port and one
// write port. Read data appears one cycle after the address. A read and
// a write to the same address in one cycle return the old byte.
// Assumes no reset on the array; contents come from the preload path.
module acc8_ram #(
    parameter int DW = 8,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [0:DEPTH-1];

    // Write port and registered read port
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata <= mem_q[raddr];
    end

endmodule

// File: rtl/acc8_alu.sv
// Module: accumulator ALU. One shared adder covers add, subtract and
// the carry variants; logic functions and shifts are computed beside it.
// Assumes the caller selects which result is written back.
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic [2:0]    fn,
    input  logic [1:0]    sh,
    output logic [DW-1:0] arith_res,
    output logic          arith_c,
    output logic          arith_cupd,
    output logic [DW-1:0] shift_res,
    output logic          shift_c
);
    logic [DW:0]   sum;
    logic [DW-1:0] b_eff;
    logic          c_in_eff;

    // Shared adder: invert operand for subtract forms, pick carry-in
    always_comb begin
        b_eff    = (fn == FN_SUB || fn == FN_SBB) ? ~b : b;
        c_in_eff = (fn == FN_ADD) ? 1'b0 : (fn == FN_SUB) ? 1'b1 : cin;
        sum      = {1'b0, a} + {1'b0, b_eff} + (DW+1)'(c_in_eff);
    end

    // Function select and carry update flag
    always_comb begin
        arith_cupd = ~fn[2];
        arith_c    = sum[DW];
        case (fn)
            FN_AND:  arith_res = a & b;
            FN_OR:   arith_res = a | b;
            FN_XOR:  arith_res = a ^ b;
            FN_PASS: arith_res = b;
            default: arith_res = sum[DW-1:0];
        endcase
    end

    // Shift and rotate through carry
    always_comb begin
        case (sh)
            SH_LEFT:  {shift_c, shift_res} = {a, 1'b0};
            SH_RIGHT: {shift_res, shift_c} = {1'b0, a};
            SH_RLC:   {shift_c, shift_res} = {a, cin};
            default:  {shift_res, shift_c} = {cin, a};
        endcase
    end

endmodule

// File: rtl/acc8_core.sv
// Module: sequential 8-bit accumulator core around one shared memory.
// The read address is chosen combinationally for the next cycle, so an
// instruction's last cycle also issues the next fetch. Program lives in
// the lower half, data and registers in the upper half.
// Assumes DW = 8 (instruction fields are fixed to one byte).
module acc8_core
    import acc8_pkg::*;
#(
    parameter int          DW     = 8,
    parameter int          REG_W  = 4,
    parameter logic [3:0]  IO_OUT = 4'h0,
    parameter logic [3:0]  IO_IN  = 4'h1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_we,
    input  logic [DW:0]     load_addr,
    input  logic [DW-1:0]   load_data,
    input  logic [DW-1:0]   in_data,
    output logic [DW-1:0]   out_data,
    output logic            out_valid,
    output logic            halted,
    output logic [DW-1:0]   acc_o
);
    localparam int            AW      = DW + 1;
    localparam logic [3:0]    IO_EXIT = 4'hF;
    localparam logic [DW-1:0] ONE     = DW'(1);
    localparam logic [DW-1:0] TWO     = DW'(2);

    state_t        state_q, state_d;
    logic [DW-1:0] pc_q, pc_d;
    logic [DW-1:0] acc_q, acc_d;
    logic          carry_q, carry_d;
    logic [6:0]    ir_q, ir_d;       // opcode nibble + low three bits
    logic [DW-1:0] out_data_q, out_data_d;
    logic          out_valid_q, out_valid_d;

    logic [AW-1:0] rd_addr, core_waddr, mem_waddr;
    logic [DW-1:0] core_wdata, mem_wdata, mem_rdata;
    logic          core_we, mem_we;

    logic [2:0]    alu_fn;
    logic [DW-1:0] arith_res, shift_res;
    logic          arith_c, arith_cupd, shift_c;
    logic          br_taken;

    // Register file address inside the data half
    function automatic logic [AW-1:0] reg_addr(input logic [REG_W-1:0] r);
        return {1'b1, {(DW-REG_W){1'b0}}, r};
    endfunction

    // Preload port overrides the core write port
    always_comb begin
        mem_we    = load_we | core_we;
        mem_waddr = load_we ? load_addr : core_waddr;
        mem_wdata = load_we ? load_data : core_wdata;
    end

    acc8_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (mem_rdata)
    );

    // ALU function comes from the latched opcode field of the current form
    always_comb begin
        alu_fn = (state_q == ST_IMMOP) ? ir_q[2:0] : ir_q[5:3];
    end

    acc8_alu #(.DW(DW)) u_alu (
        .a          (acc_q),
        .b          (mem_rdata),
        .cin        (carry_q),
        .fn         (alu_fn),
        .sh         (mem_rdata[1:0]),
        .arith_res  (arith_res),
        .arith_c    (arith_c),
        .arith_cupd (arith_cupd),
        .shift_res  (shift_res),
        .shift_c    (shift_c)
    );

    // Branch decision: link form always jumps, else condition code
    always_comb begin
        if (ir_q[6:3] == OP_BAL) begin
            br_taken = 1'b1;
        end else begin
            case (ir_q[1:0])
                CC_ALWAYS:  br_taken = 1'b1;
                CC_ZERO:    br_taken = (acc_q == '0);
                CC_NONZERO: br_taken = (acc_q != '0);
                default:    br_taken = 1'b0;
            endcase
        end
    end

    // Sequencer: next state, next read address, writes and register updates
    always_comb begin
        state_d     = state_q;
        pc_d        = pc_q;
        acc_d       = acc_q;
        carry_d     = carry_q;
        ir_d        = ir_q;
        out_data_d  = out_data_q;
        out_valid_d = 1'b0;
        rd_addr     = {1'b0, pc_q};
        core_we     = 1'b0;
        core_waddr  = '0;
        core_wdata  = acc_q;
        case (state_q)
            ST_BOOT: begin
                state_d = ST_DEC;
            end
            ST_DEC: begin
                ir_d = {mem_rdata[7:4], mem_rdata[2:0]};
                if (!mem_rdata[7]) begin
                    rd_addr = reg_addr(mem_rdata[REG_W-1:0]);
                    state_d = ST_REGOP;
                end else begin
                    case (mem_rdata[7:4])
                        OP_STREG: begin
                            core_we    = 1'b1;
                            core_waddr = reg_addr(mem_rdata[REG_W-1:0]);
                            pc_d       = pc_q + ONE;
                            rd_addr    = {1'b0, pc_q + ONE};
                        end
                        OP_BAL: begin
                            core_we    = 1'b1;
                            core_waddr = reg_addr(mem_rdata[REG_W-1:0]);
                            core_wdata = pc_q + TWO;
                            rd_addr    = {1'b0, pc_q + ONE};
                            state_d    = ST_BRANCH;
                        end
                        OP_LDIND: begin
                            rd_addr = reg_addr(mem_rdata[REG_W-1:0]);
                            state_d = ST_LDPTR;
                        end
                        OP_STIND: begin
                            rd_addr = reg_addr(mem_rdata[REG_W-1:0]);
                            state_d = ST_STPTR;
                        end
                        OP_IMM: begin
                            rd_addr = {1'b0, pc_q + ONE};
                            state_d = ST_IMMOP;
                        end
                        OP_BR: begin
                            rd_addr = {1'b0, pc_q + ONE};
                            state_d = ST_BRANCH;
                        end
                        OP_SHIFT: begin
                            acc_d   = shift_res;
                            carry_d = shift_c;
                            pc_d    = pc_q + ONE;
                            rd_addr = {1'b0, pc_q + ONE};
                        end
                        default: begin  // IO group
                            if (mem_rdata[3:0] == IO_EXIT) begin
                                state_d = ST_HALT;
                            end else begin
                                if (mem_rdata[3:0] == IO_OUT) begin
                                    out_valid_d = 1'b1;
                                    out_data_d  = acc_q;
                                end else if (mem_rdata[3:0] == IO_IN) begin
                                    acc_d = in_data;
                                end
                                pc_d    = pc_q + ONE;
                                rd_addr = {1'b0, pc_q + ONE};
                            end
                        end
                    endcase
                end
            end
            ST_REGOP: begin
                acc_d   = arith_res;
                carry_d = arith_cupd ? arith_c : carry_q;
                pc_d    = pc_q + ONE;
                rd_addr = {1'b0, pc_q + ONE};
                state_d = ST_DEC;
            end
            ST_IMMOP: begin
                acc_d   = arith_res;
                carry_d = arith_cupd ? arith_c : carry_q;
                pc_d    = pc_q + TWO;
                rd_addr = {1'b0, pc_q + TWO};
                state_d = ST_DEC;
            end
            ST_BRANCH: begin
                pc_d    = br_taken ? mem_rdata : pc_q + TWO;
                rd_addr = {1'b0, pc_d};
                state_d = ST_DEC;
            end
            ST_LDPTR: begin
                rd_addr = {1'b1, mem_rdata};
                state_d = ST_LDDAT;
            end
            ST_LDDAT: begin
                acc_d   = mem_rdata;
                pc_d    = pc_q + ONE;
                rd_addr = {1'b0, pc_q + ONE};
                state_d = ST_DEC;
            end
            ST_STPTR: begin
                core_we    = 1'b1;
                core_waddr = {1'b1, mem_rdata};
                pc_d       = pc_q + ONE;
                rd_addr    = {1'b0, pc_q + ONE};
                state_d    = ST_DEC;
            end
            default: begin  // ST_HALT: no fetch progress
                state_d = ST_HALT;
            end
        endcase
    end

    // Architectural and control registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_BOOT;
            pc_q        <= '0;
            acc_q       <= '0;
            carry_q     <= 1'b0;
            ir_q        <= '0;
            out_data_q  <= '0;
            out_valid_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            pc_q        <= pc_d;
            acc_q       <= acc_d;
            carry_q     <= carry_d;
            ir_q        <= ir_d;
            out_data_q  <= out_data_d;
            out_valid_q <= out_valid_d;
        end
    end

    // Output drive
    always_comb begin
        out_data  = out_data_q;
        out_valid = out_valid_q;
        halted    = (state_q == ST_HALT);
        acc_o     = acc_q;
    end

endmodule

// File: rtl/acc8_core_chk.sv
// Module: property checker for acc8_core, attached with bind below.
// Watches the ports plus the sequencer state and the read-port byte.
module acc8_core_chk
    import acc8_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] acc_o,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       halted,
    input state_t     fsm_state,
    input logic [7:0] fetch_byte
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (acc_o == 8'h00 && !halted && !out_valid));

    // R10
    out_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == acc_o));

    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (!out_valid && $stable(acc_o)));

    // R5
    store_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DEC && fetch_byte[7:4] == OP_STREG) |=> (fsm_state == ST_DEC));

    // R6
    ldind_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_LDPTR) |=> (fsm_state == ST_LDDAT));

endmodule

bind acc8_core acc8_core_chk u_acc8_core_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_o      (acc_o),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .halted     (halted),
    .fsm_state  (state_q),
    .fetch_byte (mem_rdata)
);

// File: tb/test_acc8_core.sv
// Directed bench: each task assembles a short program, preloads it,
// runs the core to its exit and checks the output-port stream, the
// spacing of out_valid pulses and the halt behaviour.
module test_acc8_core;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       load_we;
    logic [8:0] load_addr;
    logic [7:0] load_data;
    logic [7:0] in_data;
    logic [7:0] out_data;
    logic       out_valid;
    logic       halted;
    logic [7:0] acc_o;

    always #2 clk = ~clk;  // 250 MHz

    acc8_core i_acc8_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data),
        .in_data   (in_data),
        .out_data  (out_data),
        .out_valid (out_valid),
        .halted    (halted),
        .acc_o     (acc_o)
    );

    int n_chk = 0;
    int n_err = 0;
    int wd_cyc = 0;

    logic [7:0] img [0:511];
    int         wp;
    logic [7:0] sv [0:63];
    int         sc [0:63];
    int         ns;
    int         halt_cyc;
    logic       quiet_ok;
    logic [7:0] acc_halt;
    logic [7:0] rst_acc;
    logic       rst_valid, rst_halt;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Program builder helpers
    task automatic clear_img();
        for (int i = 0; i < 512; i++) img[i] = 8'h00;
        wp = 0;
    endtask
    task automatic put(input logic [7:0] b);
        img[wp] = b;
        wp++;
    endtask
    task automatic imm(input logic [2:0] f, input logic [7:0] n);
        put({5'b11000, f}); put(n);
    endtask
    task automatic alu_r(input logic [2:0] f, input logic [3:0] r); put({1'b0, f, r}); endtask
    task automatic st_r(input logic [3:0] r);   put({4'h8, r}); endtask
    task automatic ld_ind(input logic [3:0] r); put({4'hA, r}); endtask
    task automatic st_ind(input logic [3:0] r); put({4'hB, r}); endtask
    task automatic shf(input logic [1:0] s);    put({6'b111000, s}); endtask
    task automatic op_out();  put(8'hF0); endtask
    task automatic op_in();   put(8'hF1); endtask
    task automatic op_exit(); put(8'hFF); endtask

    // Preload under reset, release, collect strobes until halt
    task automatic run_prog(input int max_cyc);
        int cyc;
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 512; i++) begin
            load_we   = 1'b1;
            load_addr = i[8:0];
            load_data = img[i];
            @(negedge clk);
        end
        load_we   = 1'b0;
        rst_acc   = acc_o;
        rst_valid = out_valid;
        rst_halt  = halted;
        ns       = 0;
        halt_cyc = -1;
        cyc      = 0;
        rst_n    = 1'b1;
        while (halt_cyc < 0 && cyc < max_cyc) begin
            @(negedge clk);
            cyc++;
            if (out_valid && ns < 64) begin
                sv[ns] = out_data;
                sc[ns] = cyc;
                ns++;
            end
            if (halted) halt_cyc = cyc;
        end
        chk("R11", "program reached exit", int'(halt_cyc >= 0), 1);
        acc_halt = acc_o;
        quiet_ok = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (out_valid || !halted || acc_o != acc_halt) quiet_ok = 1'b0;
        end
    endtask

    // R1: reset values and first fetch from address 0
    task automatic t_reset();
        clear_img();
        op_out();
        op_exit();
        run_prog(100);
        chk("R1", "acc under reset", rst_acc, 0);
        chk("R1", "out_valid under reset", rst_valid, 0);
        chk("R1", "halted under reset", rst_halt, 0);
        chk("R1", "strobe count", ns, 1);
        chk("R1", "first OUT value", sv[0], 8'h00);
        chk("R1", "first OUT cycle", sc[0], 2);
        chk("R11", "halt cycle", halt_cyc, 3);
    endtask

    // R3: immediate ALU forms and their timing
    task automatic t_imm();
        clear_img();
        imm(3'd7, 8'h5A); op_out();
        imm(3'd0, 8'h10); op_out();
        imm(3'd1, 8'h0B); op_out();
        imm(3'd4, 8'h0F); op_out();
        imm(3'd5, 8'h30); op_out();
        imm(3'd6, 8'hFF); op_out();
        put(8'hCF); put(8'h11); op_out();   // bit 3 set: still pass
        op_exit();
        run_prog(200);
        chk("R3", "strobe count", ns, 7);
        chk("R3", "pass 5A", sv[0], 8'h5A);
        chk("R3", "add", sv[1], 8'h6A);
        chk("R3", "sub", sv[2], 8'h5F);
        chk("R3", "and", sv[3], 8'h0F);
        chk("R3", "or", sv[4], 8'h3F);
        chk("R3", "xor", sv[5], 8'hC0);
        chk("R3", "bit3 ignored", sv[6], 8'h11);
        chk("R3", "immediate op 2 cycles", sc[1] - sc[0], 3);
    endtask

    // R4: carry production and consumption
    task automatic t_carry();
        clear_img();
        imm(3'd7, 8'hF0); imm(3'd0, 8'h20); op_out();
        imm(3'd2, 8'h00); op_out();
        imm(3'd7, 8'h05); imm(3'd1, 8'h06); op_out();
        imm(3'd3, 8'h00); op_out();
        imm(3'd4, 8'hFF); imm(3'd2, 8'h01); op_out();
        imm(3'd2, 8'h00); op_out();
        op_exit();
        run_prog(200);
        chk("R4", "strobe count", ns, 6);
        chk("R4", "add overflow result", sv[0], 8'h10);
        chk("R4", "adc uses carry 1", sv[1], 8'h11);
        chk("R4", "sub with borrow", sv[2], 8'hFF);
        chk("R4", "sbb after borrow", sv[3], 8'hFE);
        chk("R4", "and keeps carry, adc", sv[4], 8'h00);
        chk("R4", "adc sees carry from 0x100", sv[5], 8'h01);
    endtask

    // R2, R5: register operands and single-cycle register store
    task automatic t_regs();
        clear_img();
        imm(3'd7, 8'h33); st_r(4'd3);
        imm(3'd7, 8'h11); op_out();
        alu_r(3'd0, 4'd3); op_out();
        alu_r(3'd6, 4'd3); op_out();
        alu_r(3'd7, 4'd3); op_out();
        st_r(4'd5); op_out();
        alu_r(3'd1, 4'd5); op_out();
        op_exit();
        run_prog(200);
        chk("R2", "strobe count", ns, 6);
        chk("R2", "add r3", sv[1], 8'h44);
        chk("R2", "xor r3", sv[2], 8'h77);
        chk("R2", "pass r3", sv[3], 8'h33);
        chk("R2", "sub r5", sv[5], 8'h00);
        chk("R2", "register op 2 cycles", sc[1] - sc[0], 3);
        chk("R5", "store 1 cycle", sc[4] - sc[3], 2);
    endtask

    // R6: indirect load/store, timing and register aliasing
    task automatic t_indirect();
        clear_img();
        imm(3'd7, 8'h80); st_r(4'd1);
        imm(3'd7, 8'hA5); op_out();
        st_ind(4'd1); op_out();
        imm(3'd7, 8'h00); op_out();
        ld_ind(4'd1); op_out();
        imm(3'd7, 8'h02); st_r(4'd1);
        imm(3'd7, 8'h3C); st_ind(4'd1);
        imm(3'd7, 8'h00); alu_r(3'd7, 4'd2); op_out();
        op_exit();
        run_prog(300);
        chk("R6", "strobe count", ns, 5);
        chk("R6", "indirect store 2 cycles", sc[1] - sc[0], 3);
        chk("R6", "indirect load value", sv[3], 8'hA5);
        chk("R6", "indirect load 3 cycles", sc[3] - sc[2], 4);
        chk("R6", "pointer 02 aliases r2", sv[4], 8'h3C);
    endtask

    // R7: conditional and unconditional branches
    task automatic t_branch();
        int p;
        clear_img();
        img[8'hF0] = 8'hFF;  // wrong jump target exits early
        imm(3'd7, 8'h00); op_out();
        p = wp; put(8'hD1); put(8'h00); imm(3'd7, 8'hEE); op_out(); img[p+1] = wp[7:0];
        op_out();
        imm(3'd7, 8'h01); op_out();
        put(8'hD1); put(8'hF0); op_out();
        p = wp; put(8'hD2); put(8'h00); imm(3'd7, 8'hEE); op_out(); img[p+1] = wp[7:0];
        op_out();
        put(8'hD3); put(8'hF0); op_out();
        p = wp; put(8'hD0); put(8'h00); imm(3'd7, 8'hEE); op_out(); img[p+1] = wp[7:0];
        op_out();
        op_exit();
        run_prog(300);
        chk("R7", "strobe count", ns, 7);
        chk("R7", "zero taken skips poison", sv[1], 8'h00);
        chk("R7", "zero taken 2 cycles", sc[1] - sc[0], 3);
        chk("R7", "zero untaken 2 cycles", sc[3] - sc[2], 3);
        chk("R7", "nonzero taken value", sv[4], 8'h01);
        chk("R7", "nonzero taken 2 cycles", sc[4] - sc[3], 3);
        chk("R7", "never untaken 2 cycles", sc[5] - sc[4], 3);
        chk("R7", "always taken value", sv[6], 8'h01);
        chk("R7", "always taken 2 cycles", sc[6] - sc[5], 3);
    endtask

    // R8: branch-and-link saves return address
    task automatic t_link();
        int p;
        clear_img();
        imm(3'd7, 8'h00); op_out();
        p = wp; put(8'h94); put(8'h00); imm(3'd7, 8'hEE); op_out(); img[p+1] = wp[7:0];
        op_out();
        alu_r(3'd7, 4'd4); op_out();
        op_exit();
        run_prog(200);
        chk("R8", "strobe count", ns, 3);
        chk("R8", "jump taken 2 cycles", sc[1] - sc[0], 3);
        chk("R8", "saved link", sv[2], p + 2);
    endtask

    // R9: shifts and rotates through carry
    task automatic t_shift();
        clear_img();
        imm(3'd7, 8'h81); shf(2'd0); op_out();
        shf(2'd2); op_out();
        shf(2'd1); op_out();
        shf(2'd3); op_out();
        imm(3'd2, 8'h00); op_out();
        op_exit();
        run_prog(200);
        chk("R9", "strobe count", ns, 5);
        chk("R9", "shift left", sv[0], 8'h02);
        chk("R9", "rotate left via carry", sv[1], 8'h05);
        chk("R9", "shift right", sv[2], 8'h02);
        chk("R9", "rotate right via carry", sv[3], 8'h81);
        chk("R9", "carry after rotate right", sv[4], 8'h81);
        chk("R9", "shift 1 cycle", sc[1] - sc[0], 2);
    endtask

    // R10: input, output and unused IO selects
    task automatic t_io();
        clear_img();
        in_data = 8'h9C;
        imm(3'd7, 8'h00); op_out();
        op_in(); op_out();
        put(8'hF5); op_out();
        op_exit();
        run_prog(200);
        chk("R10", "strobe count", ns, 3);
        chk("R10", "out before input", sv[0], 8'h00);
        chk("R10", "input loaded", sv[1], 8'h9C);
        chk("R10", "input 1 cycle", sc[1] - sc[0], 2);
        chk("R10", "unused select no effect", sv[2], 8'h9C);
        chk("R10", "unused select 1 cycle", sc[2] - sc[1], 2);
        in_data = 8'h00;
    endtask

    // R11: exit halts and freezes the core
    task automatic t_exit();
        clear_img();
        imm(3'd7, 8'h42); op_exit(); op_out(); imm(3'd7, 8'h00);
        run_prog(200);
        chk("R11", "no strobe after exit", ns, 0);
        chk("R11", "halt cycle", halt_cyc, 4);
        chk("R11", "accumulator at halt", acc_halt, 8'h42);
        chk("R11", "halted quiet and stable", quiet_ok, 1);
    endtask

    // R12: preloaded data bytes are visible to the program
    task automatic t_preload();
        clear_img();
        img[256 + 8'h90] = 8'h6D;
        img[256 + 7]     = 8'h05;
        imm(3'd7, 8'h90); st_r(4'd0); ld_ind(4'd0);
        alu_r(3'd0, 4'd7); op_out();
        op_exit();
        run_prog(200);
        chk("R12", "strobe count", ns, 1);
        chk("R12", "preloaded data and register", sv[0], 8'h72);
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            wd_cyc++;
            if (wd_cyc > 150000) begin
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd_cyc);
                $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
                $finish;
            end
        end
    end

    initial begin
        rst_n     = 1'b0;
        load_we   = 1'b0;
        load_addr = '0;
        load_data = '0;
        in_data   = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_imm();
        t_carry();
        t_regs();
        t_indirect();
        t_branch();
        t_link();
        t_shift();
        t_io();
        t_exit();
        t_preload();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule